// File: doc/BRIEF.md
# Active-Video Code Protector and Blanker

This block conditions a parallel video stream that carries one 10-bit luma word and one 10-bit chroma word on every pixel clock. A word-synchronous blanking control can replace both channels at once with their blanking levels. When the protection enable is set, the block also clamps reserved code values that fall inside the active picture, which is marked by a qualifier input. Words outside the active picture are never clamped. Timing references and ancillary words sent during blanking therefore pass through intact.

Blanking is applied first and clamping second. One register stage sits between input and output, and the qualifier is delayed by that same stage so it stays aligned with the data. Each channel is clamped on its own value: a reserved luma word does not affect the chroma word, and a reserved chroma word does not affect the luma word.

Top module: `vcp_stream_cond`

## Requirements
- R1: The output pair reflects the input pair sampled at the previous rising clock edge (one register stage). It does not change between edges.
- R2: `act_out` equals `act_in` delayed by one clock.
- R3: With `protect_en` high and `act_in` high, any channel word in 0x000..0x003 leaves as 0x004.
- R4: With `protect_en` high and `act_in` high, any channel word in 0x3FC..0x3FF leaves as 0x3FB.
- R5: With protection active, words in 0x004..0x3FB pass unchanged.
- R6: With `protect_en` low, every word passes unchanged, reserved codes included.
- R7: When `act_in` is low, no word is remapped, whatever the state of `protect_en`.
- R8: When `blank_n` is low, luma leaves as 0x040 and chroma leaves as 0x200 on that word, regardless of the data, `act_in` or `protect_en`.
- R9: Luma (`pix_in[19:10]`) and chroma (`pix_in[9:0]`) are clamped independently, each according to its own value.
- R10: While reset is held, the outputs show luma 0x040, chroma 0x200 and `act_out` low. The asynchronous active-low reset is released synchronously, two clocks after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blank_n | input | 1 | Low forces both channels of this word to blanking levels |
| protect_en | input | 1 | High enables reserved-code clamping inside active video |
| act_in | input | 1 | High marks the word as part of the active picture |
| pix_in | input | 20 | Luma in [19:10], chroma in [9:0] |
| pix_out | output | 20 | Conditioned words, same layout as `pix_in` |
| act_out | output | 1 | `act_in` delayed to align with `pix_out` |

## Verification
Several properties are checked on every clock once reset has settled. These cover the blanking levels after a blanked word, the one-clock alignment of the qualifier, the clamp targets for both reserved bands, the absence of reserved codes in active output while protection is on, and transparency when protection is off or the word lies outside the active picture. The directed scenarios cover behaviour the properties cannot express. These include the reset values, the fact that the output holds steady between edges, every boundary code of both reserved bands on both channels, and mixed words in which one channel is clamped while the other passes through.

// File: rtl/vcp_pkg.sv
package vcp_pkg;
  localparam int unsigned WORD_W = 10;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned BUS_W  = WORD_W * NUM_CH;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BUS_W-1:0]  bus_t;
endpackage

// File: rtl/vcp_rst_sync.sv
module vcp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/vcp_blanker.sv
module vcp_blanker
  import vcp_pkg::*;
#(
  parameter word_t Y_LEVEL = 10'h040,
  parameter word_t C_LEVEL = 10'h200
) (
  input  logic blank_n,
  input  bus_t pix_i,
  output bus_t pix_o
);
  always_comb begin
    if (blank_n) pix_o = pix_i;
    else         pix_o = {Y_LEVEL, C_LEVEL};
  end
endmodule

// File: rtl/vcp_clamp.sv
module vcp_clamp
  import vcp_pkg::*;
#(
  parameter word_t LOW_LEGAL  = 10'h004,
  parameter word_t HIGH_LEGAL = 10'h3FB
) (
  input  logic  en,
  input  word_t word_i,
  output word_t word_o
);
  always_comb begin
    word_o = word_i;
    if (en) begin
      if (word_i < LOW_LEGAL)       word_o = LOW_LEGAL;
      else if (word_i > HIGH_LEGAL) word_o = HIGH_LEGAL;
    end
  end
endmodule

// File: rtl/vcp_stream_cond.sv
module vcp_stream_cond
  import vcp_pkg::*;
#(
  parameter word_t       Y_BLANK     = 10'h040,
  parameter word_t       C_BLANK     = 10'h200,
  parameter word_t       LOW_LEGAL   = 10'h004,
  parameter word_t       HIGH_LEGAL  = 10'h3FB,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        blank_n,
  input  logic        protect_en,
  input  logic        act_in,
  input  logic [19:0] pix_in,
  output logic [19:0] pix_out,
  output logic        act_out
);
  localparam bus_t RESET_BUS = {Y_BLANK, C_BLANK};

  logic rst_q_n;
  bus_t blanked;
  bus_t clamped;
  bus_t pix_d, pix_q;
  logic act_d, act_q;
  logic clamp_en;

  vcp_rst_sync #(.STAGES(SYNC_STAGES)) rst_sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  vcp_blanker #(.Y_LEVEL(Y_BLANK), .C_LEVEL(C_BLANK)) blank_i (
    .blank_n (blank_n),
    .pix_i   (pix_in),
    .pix_o   (blanked)
  );

  assign clamp_en = protect_en & act_in;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    vcp_clamp #(.LOW_LEGAL(LOW_LEGAL), .HIGH_LEGAL(HIGH_LEGAL)) clamp_i (
      .en     (clamp_en),
      .word_i (blanked[ch*WORD_W +: WORD_W]),
      .word_o (clamped[ch*WORD_W +: WORD_W])
    );
  end

  always_comb begin
    pix_d = clamped;
    act_d = act_in;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      pix_q <= RESET_BUS;
      act_q <= 1'b0;
    end else begin
      pix_q <= pix_d;
      act_q <= act_d;
    end
  end

  assign pix_out = pix_q;
  assign act_out = act_q;
endmodule

// File: rtl/vcp_stream_cond_chk.sv
module vcp_stream_cond_chk (
  input logic        clk,
  input logic        rst_q_n,
  input logic        blank_n,
  input logic        protect_en,
  input logic        act_in,
  input logic [19:0] pix_in,
  input logic [19:0] pix_out,
  input logic        act_out
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) past_ok <= 1'b0;
    else          past_ok <= 1'b1;
  end

  // R8
  a_r8_blank_levels: assert property (@(posedge clk) disable iff (!rst_q_n)
    past_ok && $past(!blank_n) |-> pix_out == {10'h040, 10'h200});

  // R2
  a_r2_act_delay: assert property (@(posedge clk) disable iff (!rst_q_n)
    past_ok |-> act_out == $past(act_in));

  // R3
  a_r3_low_band: assert property (@(posedge clk) disable iff (!rst_q_n)
    past_ok && $past(blank_n && protect_en && act_in && pix_in[19:10] < 10'h004)
      |-> pix_out[19:10] == 10'h004);

  // R4
  a_r4_high_band: assert property (@(posedge clk) disable iff (!rst_q_n)
    past_ok && $past(blank_n && protect_en && act_in && pix_in[9:0] > 10'h3FB)
      |-> pix_out[9:0] == 10'h3FB);

  // R5
  a_r5_legal_out: assert property (@(posedge clk) disable iff (!rst_q_n)
    past_ok && $past(protect_en && act_in)
      |-> pix_out[19:10] >= 10'h004 && pix_out[19:10] <= 10'h3FB &&
          pix_out[9:0] >= 10'h004 && pix_out[9:0] <= 10'h3FB);

  // R6
  a_r6_off_transparent: assert property (@(posedge clk) disable iff (!rst_q_n)
    past_ok && $past(blank_n && !protect_en) |-> pix_out == $past(pix_in));

  // R7
  a_r7_outside_transparent: assert property (@(posedge clk) disable iff (!rst_q_n)
    past_ok && $past(blank_n && !act_in) |-> pix_out == $past(pix_in));
endmodule

bind vcp_stream_cond vcp_stream_cond_chk chk_i (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .blank_n    (blank_n),
  .protect_en (protect_en),
  .act_in     (act_in),
  .pix_in     (pix_in),
  .pix_out    (pix_out),
  .act_out    (act_out)
);

// File: tb/vcp_stream_cond_tb_top.sv
module vcp_stream_cond_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        blank_n;
  logic        protect_en;
  logic        act_in;
  logic [19:0] pix_in;
  logic [19:0] pix_out;
  logic        act_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  vcp_stream_cond dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .blank_n    (blank_n),
    .protect_en (protect_en),
    .act_in     (act_in),
    .pix_in     (pix_in),
    .pix_out    (pix_out),
    .act_out    (act_out)
  );

  function automatic logic [9:0] expect_word(logic [9:0] v, logic bn, logic pe,
                                             logic act, logic [9:0] lvl);
    if (!bn) return lvl;
    if (pe && act) begin
      if (v <= 10'h003) return 10'h004;
      if (v >= 10'h3FC) return 10'h3FB;
    end
    return v;
  endfunction

  task automatic check(string req, logic [20:0] actual, logic [20:0] expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, actual, expected);
    end
  endtask

  // Drive at a falling edge; the result is sampled at the next falling edge.
  task automatic word(string req, logic bn, logic pe, logic act,
                      logic [9:0] y, logic [9:0] c);
    logic [20:0] prev;
    blank_n = bn; protect_en = pe; act_in = act; pix_in = {y, c};
    prev = {act_out, pix_out};
    #1;
    check({req, " R1 hold"}, {act_out, pix_out}, prev);
    @(negedge clk);
    check(req, {act_out, pix_out},
          {act, expect_word(y, bn, pe, act, 10'h040), expect_word(c, bn, pe, act, 10'h200)});
  endtask

  task automatic t_reset;
    rst_n = 1'b0; blank_n = 1'b1; protect_en = 1'b0; act_in = 1'b1; pix_in = 20'hABCDE;
    repeat (3) @(negedge clk);
    check("R10 reset", {act_out, pix_out}, {1'b0, 10'h040, 10'h200});
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 still held", {act_out, pix_out}, {1'b0, 10'h040, 10'h200});
    repeat (2) @(negedge clk);
  endtask

  task automatic t_low_band;
    for (int v = 0; v < 4; v++) word("R3 luma low", 1'b1, 1'b1, 1'b1, 10'(v), 10'h155);
    for (int v = 0; v < 4; v++) word("R3 chroma low", 1'b1, 1'b1, 1'b1, 10'h2AA, 10'(v));
  endtask

  task automatic t_high_band;
    for (int v = 10'h3FC; v <= 10'h3FF; v++) word("R4 both high", 1'b1, 1'b1, 1'b1, 10'(v), 10'(v));
  endtask

  task automatic t_legal;
    word("R5 edges", 1'b1, 1'b1, 1'b1, 10'h004, 10'h3FB);
    word("R5 mid",   1'b1, 1'b1, 1'b1, 10'h200, 10'h040);
  endtask

  task automatic t_protect_off;
    word("R6 off low",  1'b1, 1'b0, 1'b1, 10'h000, 10'h003);
    word("R6 off high", 1'b1, 1'b0, 1'b1, 10'h3FF, 10'h3FC);
  endtask

  task automatic t_outside;
    word("R7 timing ref", 1'b1, 1'b1, 1'b0, 10'h3FF, 10'h3FF);
    word("R7 zeros",      1'b1, 1'b1, 1'b0, 10'h000, 10'h000);
  endtask

  task automatic t_blank;
    word("R8 blank reserved", 1'b0, 1'b1, 1'b1, 10'h3FF, 10'h000);
    word("R8 blank outside",  1'b0, 1'b0, 1'b0, 10'h123, 10'h321);
  endtask

  task automatic t_independent;
    word("R9 luma only",   1'b1, 1'b1, 1'b1, 10'h001, 10'h180);
    word("R9 chroma only", 1'b1, 1'b1, 1'b1, 10'h0F0, 10'h3FE);
  endtask

  task automatic t_stream;
    for (int i = 0; i < 16; i++)
      word("R2 R1 stream", 1'b1, 1'b1, i[0], 10'(i * 67), 10'(1023 - i * 67));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_low_band();
    t_high_band();
    t_legal();
    t_protect_off();
    t_outside();
    t_blank();
    t_independent();
    t_stream();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule